// File: doc/BRIEF.md
# Interrupt Cause Register with Non-Destructive Peek

This block is the interrupt cause slice of a network interface controller. Hardware events such as a link state change arrive as single-cycle pulses, and each sets its own bit in one shared pending register. Software reaches that register through two read addresses. A read of the acknowledge address returns the pending causes and clears them. A read of the peek address returns the same causes and leaves them in place. The peek address lets a driver look at the pending events from interrupt context and leave the acknowledge to a later thread.

Software can raise causes itself through a cause-set write address. A mask register has separate set and clear addresses and decides which pending bits drive the single level-sensitive interrupt line. The top bit of the cause register is a summary flag. Hardware holds it at one whenever any other cause bit is pending.

Top module: `evt_cause_ctrl`

## Requirements
- R1: An event pulse on `ev_i[k]` sets pending bit k at the next clock edge. A later read of either the acknowledge address (0) or the peek address (1) returns the bit as one.
- R2: A read of the acknowledge address (0) returns the pending register and clears every cause bit it returned.
- R3: A read of the peek address (1) returns the pending register and changes no bit, even when such reads are issued on back-to-back cycles.
- R4: Both read addresses show one shared register. After an acknowledge read clears a bit, a peek read returns that bit as zero.
- R5: `irq_o` is high exactly when the bitwise AND of the mask register and the pending register is non-zero. It is registered and follows the same clock edge that updates either register.
- R6: Bit DATA_W-1 of the pending register is the summary flag. It is one exactly when any of bits DATA_W-2..0 is pending.
- R7: A write to the cause-set address (2) ORs `wr_data[DATA_W-2:0]` into the pending register. Zero data bits change nothing, and data bit DATA_W-1 is ignored because the summary flag is derived.
- R8: A write to the mask-set address (4) ORs data into the mask. A write to the mask-clear address (5) clears the mask bits where the data is one. A read of the mask address (3) returns the mask.
- R9: When an event pulse coincides with an acknowledge read, the returned data excludes the new event and the event's bit stays set afterwards.
- R10: Read data appears on `rd_data` with `rd_valid` high one cycle after `rd_en`. Reads of unmapped addresses (6, 7) return zero. Writes to read-only addresses (0, 1, 3) have no effect.
- R11: A synchronous active-high reset clears the pending register, the mask, `irq_o` and `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid one cycle after the strobe |
| rd_valid | output | 1 | Marks the cycle that carries read data |
| ev_i | input | DATA_W-1 | Per-cycle hardware event pulses |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the block with DATA_W = 32. This puts the summary flag at bit 31 and gives 31 independent event lines that random traffic can hit in any mix with acknowledge reads, peeks and software sets. At that width, an event pulse can land in the same cycle as an acknowledge read on any bit, and mask bit 31 can gate the interrupt through the summary flag alone.

// File: rtl/evt_cause_pkg.sv
package evt_cause_pkg;
  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_ACK   = 3'd0,
    RA_PEEK  = 3'd1,
    RA_SET   = 3'd2,
    RA_MASK  = 3'd3,
    RA_MSET  = 3'd4,
    RA_MCLR  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/evt_pending_reg.sv
module evt_pending_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-2:0] ev_i,
  input  logic              set_en,
  input  logic [DATA_W-2:0] set_data,
  input  logic              ack_en,
  output logic [DATA_W-1:0] pend_q,
  output logic [DATA_W-1:0] pend_nxt
);
  localparam int CW = DATA_W - 1;

  logic [CW-1:0] low_nxt;

  for (genvar i = 0; i < CW; i++) begin : g_bit
    assign low_nxt[i] = (pend_q[i] & ~ack_en) | ev_i[i] | (set_en & set_data[i]);
  end

  assign pend_nxt = {|low_nxt, low_nxt};

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_nxt;
  end

  // R2: bits present at an acknowledge and not re-raised are gone afterwards
  a_r2_ack_clears: assert property (@(posedge clk) disable iff (rst)
    ack_en |=> ((pend_q[CW-1:0] & $past(pend_q[CW-1:0] & ~ev_i & ~(set_data & {CW{set_en}}))) == '0));

  // R3: without an acknowledge no pending bit is ever lost
  a_r3_no_loss: assert property (@(posedge clk) disable iff (rst)
    !ack_en |=> ((pend_q[CW-1:0] & $past(pend_q[CW-1:0])) == $past(pend_q[CW-1:0])));

  // R1: an event pulse is pending at the next edge
  a_r1_event_sets: assert property (@(posedge clk) disable iff (rst)
    (ev_i != '0) |=> ((pend_q[CW-1:0] & $past(ev_i)) == $past(ev_i)));

  // R6: summary flag tracks the other cause bits
  a_r6_summary: assert property (@(posedge clk) disable iff (rst)
    pend_q[CW] == (pend_q[CW-1:0] != '0));
endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] mask_nxt
);
  always_comb begin
    mask_nxt = mask_q;
    if (set_en) mask_nxt = mask_nxt | data;
    if (clr_en) mask_nxt = mask_nxt & ~data;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_nxt;
  end

  // R8: set writes raise their bits, clear writes drop theirs
  a_r8_mask_set: assert property (@(posedge clk) disable iff (rst)
    (set_en && !clr_en) |=> ((mask_q & $past(data)) == $past(data)));
  a_r8_mask_clr: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !set_en) |=> ((mask_q & $past(data)) == '0));
  a_r8_mask_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr_en && !set_en) |=> $stable(mask_q));
endmodule

// File: rtl/evt_read_port.sv
module evt_read_port
  import evt_cause_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     pend_q,
  input  logic [DATA_W-1:0]     mask_q,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_valid
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    case (addr)
      RA_ACK, RA_PEEK: sel = pend_q;
      RA_MASK:         sel = mask_q;
      default:         sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? sel : '0;
    end
  end

  // R10: one-cycle read latency
  a_r10_latency: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
endmodule

// File: rtl/evt_cause_ctrl.sv
module evt_cause_ctrl
  import evt_cause_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_valid,
  input  logic [DATA_W-2:0]     ev_i,
  output logic                  irq_o
);
  logic ack_en, cset_en, mset_en, mclr_en;
  logic [DATA_W-1:0] pend_q, pend_nxt, mask_q, mask_nxt;

  assign ack_en  = rd_en && (addr == RA_ACK);
  assign cset_en = wr_en && (addr == RA_SET);
  assign mset_en = wr_en && (addr == RA_MSET);
  assign mclr_en = wr_en && (addr == RA_MCLR);

  evt_pending_reg #(.DATA_W(DATA_W)) i_pend (
    .clk(clk), .rst(rst), .ev_i(ev_i), .set_en(cset_en),
    .set_data(wr_data[DATA_W-2:0]), .ack_en(ack_en),
    .pend_q(pend_q), .pend_nxt(pend_nxt)
  );

  evt_mask_reg #(.DATA_W(DATA_W)) i_mask (
    .clk(clk), .rst(rst), .set_en(mset_en), .clr_en(mclr_en),
    .data(wr_data), .mask_q(mask_q), .mask_nxt(mask_nxt)
  );

  evt_read_port #(.DATA_W(DATA_W)) i_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
    .pend_q(pend_q), .mask_q(mask_q),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(mask_nxt & pend_nxt);
  end

  // R5: the registered line agrees with the stored registers
  a_r5_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq_o == ((mask_q & pend_q) != '0));
endmodule

// File: tb/test_evt_cause_ctrl.sv
`timescale 1ns/1ps
module test_evt_cause_ctrl;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_en = 1'b0, wr_en = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic [DW-2:0] ev_i = '0;
  logic          irq_o;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] m_pend = '0;
  logic [DW-1:0] m_mask = '0;

  always #2.5 clk = ~clk;

  evt_cause_ctrl #(.DATA_W(DW)) i_evt_cause_ctrl (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .ev_i(ev_i), .irq_o(irq_o)
  );

  task automatic chk(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [DW-2:0] ev, input logic rd, input logic wr,
                      input logic [2:0] a, input logic [DW-1:0] d, input string tag);
    logic [DW-1:0] exp_rd;
    logic [DW-2:0] low;
    @(negedge clk);
    ev_i = ev; rd_en = rd; wr_en = wr; addr = a; wr_data = d;
    exp_rd = '0;
    if (rd) begin
      case (a)
        3'd0, 3'd1: exp_rd = m_pend;
        3'd3:       exp_rd = m_mask;
        default:    exp_rd = '0;
      endcase
    end
    low = m_pend[DW-2:0];
    if (rd && a == 3'd0) low = '0;
    if (wr && a == 3'd2) low = low | d[DW-2:0];
    low = low | ev;
    m_pend = {(low != '0), low};
    if (wr && a == 3'd4) m_mask = m_mask | d;
    if (wr && a == 3'd5) m_mask = m_mask & ~d;
    @(posedge clk);
    #1;
    chk({31'd0, rd_valid}, {31'd0, rd}, "R10 valid");
    if (rd) chk(rd_data, exp_rd, tag);
    chk({31'd0, irq_o}, {31'd0, (m_mask & m_pend) != '0}, "R5 irq");
    ev_i = '0; rd_en = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk({31'd0, irq_o}, 32'd0, "R11 irq");
    chk({31'd0, rd_valid}, 32'd0, "R11 valid");
    step('0, 1, 0, 3'd1, '0, "R11 pending");
    step('0, 1, 0, 3'd3, '0, "R11 mask");
    // event visible in both views
    step(31'h20, 0, 0, 3'd0, '0, "R1 pulse");
    step('0, 1, 0, 3'd1, '0, "R1 peek R6 summary");
    step('0, 1, 0, 3'd1, '0, "R3 peek again");
    step('0, 1, 0, 3'd0, '0, "R2 ack");
    step('0, 1, 0, 3'd1, '0, "R4 after ack");
    // software causes
    step('0, 0, 1, 3'd2, 32'h8000_0003, "R7 set");
    step('0, 1, 0, 3'd1, '0, "R7 peek");
    step('0, 0, 1, 3'd2, 32'h0, "R7 zero");
    step('0, 1, 0, 3'd1, '0, "R7 peek zero");
    // mask
    step('0, 0, 1, 3'd4, 32'h2, "R8 mset");
    step('0, 1, 0, 3'd3, '0, "R8 mask read");
    step('0, 0, 1, 3'd5, 32'h2, "R8 mclr");
    step('0, 1, 0, 3'd3, '0, "R8 mask cleared");
    step('0, 0, 1, 3'd4, 32'h8000_0000, "R5 summary mask");
    // event with acknowledge
    step(31'h200, 1, 0, 3'd0, '0, "R9 ack with event");
    step('0, 1, 0, 3'd1, '0, "R9 event kept");
    // unmapped and read-only
    step('0, 1, 0, 3'd7, '0, "R10 unmapped");
    step('0, 0, 1, 3'd1, 32'hFFFF_FFFF, "R10 ro write");
    step('0, 1, 0, 3'd1, '0, "R10 peek unchanged");
    step('0, 0, 1, 3'd3, 32'hFFFF_FFFF, "R10 ro mask write");
    step('0, 1, 0, 3'd3, '0, "R10 mask unchanged");
    step('0, 0, 1, 3'd5, 32'hFFFF_FFFF, "R8 clear all");
    for (int n = 0; n < 4000; n++) begin
      logic [DW-2:0] ev;
      logic [2:0] a;
      logic rd, wr;
      ev = ($urandom_range(0, 3) == 0) ? (31'd1 << $urandom_range(0, 30)) : '0;
      a  = 3'($urandom_range(0, 7));
      rd = ($urandom_range(0, 1) == 1);
      wr = ($urandom_range(0, 2) == 0);
      step(ev, rd, wr, a, $urandom & $urandom, (a == 3'd0) ? "R2 rand" :
           (a == 3'd1) ? "R3 rand" : (a == 3'd3) ? "R8 rand" : "R10 rand");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule